// File: doc/BRIEF.md
# I2S to TDM Channel Aligner

This block takes a stereo I2S stream on which a host carries eight audio channels. The host sends one eight-channel sample set as four back-to-back left/right word pairs. The block re-packs these words into eight-slot TDM frames. The host cannot say which received word belongs to channel 1. The block works this out by itself once the stream is running, so it makes no assumption about when the stream started.

Alignment is started with a sync command while the host sends a known pattern. In the default mode the pattern is one nonzero word per eight-word group, with every other word zero. In marker mode the flag is bit 0 of each word, and only the channel-1 word has it set. When the same position wins in two groups in a row, the block locks and reports the position as a channel offset. The TDM output stays silent after reset, and after a reset command, until an unmute command arrives. A two-frame buffer sits between the receive side and the transmit side, so the two frame phases need not match.

All logic runs on the bit clock, which is `clk_i`.

Top module: `i2s_tdm_aligner`

## Requirements
- R1: I2S words are 32 bits, sent MSB first. The first bit of a word is sampled one clock after the LRCLK transition that opens it, and its last bit is sampled on the clock where LRCLK next changes. LRCLK low carries the left word.
- R2: A word position counter starts at 0 for the first word completed after `rst_ni` is released. It advances by one per received word and wraps at 8, so one eight-word group spans four stereo pairs. `cmd_reset_i` and `cmd_sync_i` do not reset this counter.
- R3: After `cmd_sync_i`, a group whose word at position p is the only one that qualifies is a hit for p. Two back-to-back groups that hit the same p set `locked_o` to 1 and `chan_offset_o` to p. `locked_o` is 0 while a search is running.
- R4: A group with zero qualifying words, or with more than one, never produces a lock.
- R5: `chan_offset_o` gives the position of the channel-1 word. If the host shifts its channel order and sync is requested again, the new position is found.
- R6: Once locked, `locked_o` and `chan_offset_o` hold their values until the next `cmd_sync_i` or `cmd_reset_i`, even if every word becomes zero.
- R7: With `marker_mode_i` high, a word qualifies when its bit 0 is 1. With it low, a word qualifies when it is nonzero.
- R8: After `rst_ni`, and after `cmd_reset_i`, `muted_o` is 1 and `tdm_sd_o` is 0 until `cmd_unmute_i`. `cmd_reset_i` also clears the lock and sets the offset to 0.
- R9: `tdm_fs_o` is high for one clock every 256 clocks, in the clock just before the first bit of slot 0. Each slot is 32 bits, MSB first. Slot k carries channel k+1, which is the word received at position (offset + k) mod 8.
- R10: Each TDM frame carries the eight words of one complete received group, in channel order. Successive TDM frames carry successive groups.
- R11: `tdm_sd_o` is 0 whenever `locked_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock for both the I2S input and the TDM output |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrclk_i | input | 1 | I2S word select (low selects left) |
| sd_i | input | 1 | I2S serial data |
| cmd_reset_i | input | 1 | One-cycle pulse: mute the output and drop the lock |
| cmd_sync_i | input | 1 | One-cycle pulse: start a channel-1 search |
| cmd_unmute_i | input | 1 | One-cycle pulse: release the mute |
| marker_mode_i | input | 1 | 1 = qualify words by bit 0; 0 = qualify words by being nonzero |
| tdm_fs_o | output | 1 | TDM frame sync pulse |
| tdm_sd_o | output | 1 | TDM serial data |
| chan_offset_o | output | 3 | Position of the channel-1 word within a group |
| locked_o | output | 1 | 1 = aligned; 0 = searching or idle |
| muted_o | output | 1 | 1 = output is forced silent |

## Verification
The assertions check the following on every cycle:
- the output stays silent while muted or unlocked;
- the frame sync pulse is one clock wide and comes every 256 clocks;
- the lock and the offset cannot change without a command;
- the mute is released only by the unmute command.

Other behaviours can only be shown by the bench's scenarios:
- finding the right offset for different host channel orders;
- refusing to lock on ambiguous groups;
- the marker mode;
- the correct slot order and group order of the words that come out through the buffer.

// File: rtl/i2s_tdm_pkg.sv
package i2s_tdm_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CHANS      = 8;   // power of two: positions wrap naturally
  localparam int unsigned CH_W       = $clog2(CHANS);
  localparam int unsigned SLOT_BW    = $clog2(WORD_W);
  localparam int unsigned FRAME_BITS = WORD_W * CHANS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam int unsigned BUF_FRAMES = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CH_W-1:0]   slot_t;
endpackage

// File: rtl/i2s_word_rx.sv
module i2s_word_rx
  import i2s_tdm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lrclk_i,
  input  logic  sd_i,
  output logic  word_vld_o,
  output word_t word_o
);
  logic  lr_q;
  word_t sh_q;

  // last bit of a word lands on the clock where LRCLK changes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q       <= 1'b0;
      sh_q       <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      lr_q       <= lrclk_i;
      sh_q       <= {sh_q[WORD_W-2:0], sd_i};
      word_vld_o <= (lrclk_i != lr_q);
      if (lrclk_i != lr_q) word_o <= {sh_q[WORD_W-2:0], sd_i};
    end
  end
endmodule

// File: rtl/chan_locker.sv
module chan_locker
  import i2s_tdm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  word_vld_i,
  input  word_t word_i,
  input  logic  marker_mode_i,
  input  logic  sync_i,
  input  logic  clear_i,
  output logic  locked_o,
  output slot_t offset_o,
  output logic  wr_en_o,
  output slot_t wr_ch_o
);
  slot_t      pos_q, off_q, cand_q, hit_pos_q;
  logic [1:0] hits_q, hits_nx;
  slot_t      pos_nx;
  logic       srch_q, lock_q, prev_ok_q, hit, one_hit, grp_end;

  assign hit     = marker_mode_i ? word_i[0] : |word_i;
  assign grp_end = (pos_q == slot_t'(CHANS-1));

  always_comb begin
    hits_nx = hits_q;
    pos_nx  = hit_pos_q;
    if (hit) begin
      pos_nx = pos_q;
      if (hits_q != 2'd2) hits_nx = hits_q + 2'd1;  // saturate: 2 means "many"
    end
    one_hit = (hits_nx == 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      off_q     <= '0;
      cand_q    <= '0;
      hit_pos_q <= '0;
      hits_q    <= '0;
      srch_q    <= 1'b0;
      lock_q    <= 1'b0;
      prev_ok_q <= 1'b0;
    end else begin
      if (word_vld_i) begin
        pos_q <= pos_q + slot_t'(1);
        if (grp_end) begin
          hits_q    <= '0;
          prev_ok_q <= one_hit;
          cand_q    <= pos_nx;
          if (srch_q && one_hit && prev_ok_q && pos_nx == cand_q) begin
            lock_q <= 1'b1;
            srch_q <= 1'b0;
            off_q  <= pos_nx;
          end
        end else begin
          hits_q    <= hits_nx;
          hit_pos_q <= pos_nx;
        end
      end
      if (clear_i || sync_i) begin
        lock_q    <= 1'b0;
        srch_q    <= !clear_i;
        hits_q    <= '0;
        prev_ok_q <= 1'b0;
      end
      if (clear_i) off_q <= '0;
    end
  end

  assign locked_o = lock_q;
  assign offset_o = off_q;
  assign wr_en_o  = lock_q & word_vld_i;
  assign wr_ch_o  = pos_q - off_q;
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import i2s_tdm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  done_sel_i,
  input  logic  frame_ok_i,
  input  logic  gate_i,
  input  word_t rd_word_i,
  output logic  rd_sel_o,
  output slot_t rd_slot_o,
  output logic  fs_o,
  output logic  sd_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sel_q, ok_q, ok_nx, slot_end, frame_end;
  word_t            sh_q;

  assign slot_end  = &cnt_q[SLOT_BW-1:0];
  assign frame_end = &cnt_q;
  assign rd_sel_o  = frame_end ? done_sel_i : sel_q;
  assign rd_slot_o = slot_t'(cnt_q[CNT_W-1:SLOT_BW]) + slot_t'(1);
  assign ok_nx     = frame_end ? frame_ok_i : ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      ok_q  <= 1'b0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (frame_end) begin
        sel_q <= done_sel_i;  // frame to replay is fixed at the frame boundary
        ok_q  <= frame_ok_i;
      end
      if (slot_end) sh_q <= ok_nx ? rd_word_i : '0;
      else          sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  assign fs_o = frame_end;
  assign sd_o = sh_q[WORD_W-1] & gate_i;
endmodule

// File: rtl/i2s_tdm_aligner.sv
module i2s_tdm_aligner
  import i2s_tdm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lrclk_i,
  input  logic            sd_i,
  input  logic            cmd_reset_i,
  input  logic            cmd_sync_i,
  input  logic            cmd_unmute_i,
  input  logic            marker_mode_i,
  output logic            tdm_fs_o,
  output logic            tdm_sd_o,
  output logic [CH_W-1:0] chan_offset_o,
  output logic            locked_o,
  output logic            muted_o
);
  logic  word_vld, locked, wr_en, rd_sel;
  word_t word;
  slot_t wr_ch, rd_slot, offset;
  logic  wr_sel_q, done_sel_q, have_q, armed_q, muted_q;
  word_t frame_buf_q [BUF_FRAMES][CHANS];

  i2s_word_rx u_rx (
    .clk_i, .rst_ni, .lrclk_i, .sd_i,
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  chan_locker u_lock (
    .clk_i, .rst_ni,
    .word_vld_i    (word_vld),
    .word_i        (word),
    .marker_mode_i,
    .sync_i        (cmd_sync_i),
    .clear_i       (cmd_reset_i),
    .locked_o      (locked),
    .offset_o      (offset),
    .wr_en_o       (wr_en),
    .wr_ch_o       (wr_ch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      muted_q    <= 1'b1;
      wr_sel_q   <= 1'b0;
      done_sel_q <= 1'b0;
      have_q     <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      if (cmd_reset_i)       muted_q <= 1'b1;
      else if (cmd_unmute_i) muted_q <= 1'b0;
      if (!locked) begin
        armed_q  <= 1'b0;
        have_q   <= 1'b0;
        wr_sel_q <= 1'b0;
      end else if (wr_en) begin
        if (wr_ch == '0) armed_q <= 1'b1;  // only whole groups count as done
        if (wr_ch == slot_t'(CHANS-1) && armed_q) begin
          done_sel_q <= wr_sel_q;
          wr_sel_q   <= ~wr_sel_q;
          have_q     <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) frame_buf_q[wr_sel_q][wr_ch] <= word;
  end

  tdm_tx u_tx (
    .clk_i, .rst_ni,
    .done_sel_i (done_sel_q),
    .frame_ok_i (have_q & locked),
    .gate_i     (locked & ~muted_q),
    .rd_word_i  (frame_buf_q[rd_sel][rd_slot]),
    .rd_sel_o   (rd_sel),
    .rd_slot_o  (rd_slot),
    .fs_o       (tdm_fs_o),
    .sd_o       (tdm_sd_o)
  );

  assign chan_offset_o = offset;
  assign locked_o      = locked;
  assign muted_o       = muted_q;
endmodule

// File: rtl/i2s_tdm_aligner_chk.sv
module i2s_tdm_aligner_chk
  import i2s_tdm_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_reset_i,
  input logic            cmd_sync_i,
  input logic            cmd_unmute_i,
  input logic            tdm_fs_o,
  input logic            tdm_sd_o,
  input logic [CH_W-1:0] chan_offset_o,
  input logic            locked_o,
  input logic            muted_o
);
  logic [CNT_W:0] gap_q;
  logic           seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tdm_fs_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (!gap_q[CNT_W]) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r8_mute_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    muted_o |-> !tdm_sd_o);
  a_r11_unlocked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> !tdm_sd_o);
  a_r9_fs_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdm_fs_o |=> !tdm_fs_o);
  a_r9_fs_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tdm_fs_o && seen_q) |-> (gap_q == (CNT_W+1)'(FRAME_BITS-1)));
  a_r6_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !cmd_sync_i && !cmd_reset_i) |=> locked_o);
  a_r6_offset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !cmd_sync_i && !cmd_reset_i) |=> $stable(chan_offset_o));
  a_r8_reset_mutes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reset_i |=> (muted_o && !locked_o));
  a_r8_unmute_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(muted_o) |-> $past(cmd_unmute_i));
endmodule

bind i2s_tdm_aligner i2s_tdm_aligner_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_reset_i   (cmd_reset_i),
  .cmd_sync_i    (cmd_sync_i),
  .cmd_unmute_i  (cmd_unmute_i),
  .tdm_fs_o      (tdm_fs_o),
  .tdm_sd_o      (tdm_sd_o),
  .chan_offset_o (chan_offset_o),
  .locked_o      (locked_o),
  .muted_o       (muted_o)
);

// File: tb/i2s_tdm_aligner_test.sv
module i2s_tdm_aligner_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lrclk = 1'b0, sd = 1'b0;
  logic       cmd_reset = 1'b0, cmd_sync = 1'b0, cmd_unmute = 1'b0, marker_mode = 1'b0;
  logic       tdm_fs, tdm_sd, locked, muted;
  logic [2:0] offset;

  int checks = 0, errors = 0;
  int stream_mode = 0;  // 0 zeros, 1 sync pattern, 2 data, 3 data with marker
  int host_phase = 0;
  int p = 0;
  logic drv_on = 1'b0;
  logic [31:0] cap_w [8];

  always #2 clk = ~clk;

  i2s_tdm_aligner uut (
    .clk_i(clk), .rst_ni(rst_ni), .lrclk_i(lrclk), .sd_i(sd),
    .cmd_reset_i(cmd_reset), .cmd_sync_i(cmd_sync), .cmd_unmute_i(cmd_unmute),
    .marker_mode_i(marker_mode), .tdm_fs_o(tdm_fs), .tdm_sd_o(tdm_sd),
    .chan_offset_o(offset), .locked_o(locked), .muted_o(muted)
  );

  function automatic logic [31:0] host_word(int n);
    int c, f;
    logic [31:0] w;
    c = (n + host_phase) % 8;
    f = (n + host_phase) / 8;
    case (stream_mode)
      1:       w = (c == 0) ? 32'h0001_0000 : 32'h0;
      2, 3:    w = {f[23:0], 1'b1, c[2:0], 4'b0000};
      default: w = 32'h0;
    endcase
    if (stream_mode == 3 && c == 0) w[0] = 1'b1;
    return w;
  endfunction

  // I2S host: word n bit b sits at stream position 32n + 32 - b
  initial begin
    logic [31:0] w;
    wait (drv_on);
    forever begin
      @(negedge clk);
      lrclk = p[5];
      if (p == 0) sd = 1'b0;
      else begin
        w  = host_word((p - 1) / 32);
        sd = w[31 - ((p - 1) % 32)];
      end
      p++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // called at a negedge; captures the frame following the next sync pulse
  task automatic capture_frame();
    while (!tdm_fs) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      cap_w[i / 32] = {cap_w[i / 32][30:0], tdm_sd};
    end
  endtask

  task automatic expect_silent(string req);
    logic [31:0] acc;
    acc = '0;
    capture_frame();
    for (int k = 0; k < 8; k++) acc |= cap_w[k];
    chk(req, acc, 32'h0, "frame not silent");
  endtask

  task automatic expect_data(logic mk);
    logic [23:0] f0;
    logic [31:0] e;
    capture_frame();
    f0 = cap_w[0][31:8];
    for (int k = 0; k < 8; k++) begin
      e = {f0, 1'b1, 3'(k), 4'b0000};
      if (mk && k == 0) e[0] = 1'b1;
      chk("R1 R9 R10", cap_w[k], e, $sformatf("slot %0d", k));
    end
    capture_frame();
    chk("R10", {8'h0, cap_w[0][31:8]}, {8'h0, f0 + 24'd1}, "next frame group number");
    chk("R9 R10", cap_w[7][7:4], 4'b1111, "next frame last slot");
  endtask

  task automatic t_reset();
    int gap;
    chk("R8", {31'h0, muted}, 32'h1, "muted after reset");
    chk("R3", {31'h0, locked}, 32'h0, "locked after reset");
    chk("R8", {29'h0, offset}, 32'h0, "offset after reset");
    expect_silent("R8");
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tdm_fs);
    chk("R9", gap, 256, "fs period");
  endtask

  task automatic t_sync(int phase, logic mk, int mode, int exp_off);
    stream_mode = mode;
    host_phase  = phase;
    marker_mode = mk;
    wait_cyc(300);
    pulse(cmd_sync);
    wait_cyc(20);
    chk("R3", {31'h0, locked}, 32'h0, "locked during search");
    expect_silent("R11");
    wait_cyc(1200);
    chk(mk ? "R7" : "R3", {31'h0, locked}, 32'h1, "lock reached");
    chk("R5 R2", {29'h0, offset}, 32'(exp_off), "offset");
  endtask

  task automatic t_data(logic mk);
    stream_mode = mk ? 3 : 2;
    pulse(cmd_unmute);
    chk("R8", {31'h0, muted}, 32'h0, "unmuted");
    wait_cyc(1000);
    expect_data(mk);
  endtask

  task automatic t_hold(int exp_off);
    stream_mode = 0;
    wait_cyc(1500);
    chk("R6", {31'h0, locked}, 32'h1, "lock kept on zero data");
    chk("R6", {29'h0, offset}, 32'(exp_off), "offset kept on zero data");
  endtask

  task automatic t_ambiguous();
    stream_mode = 2;
    marker_mode = 1'b0;
    pulse(cmd_sync);
    wait_cyc(1500);
    chk("R4", {31'h0, locked}, 32'h0, "no lock on ambiguous groups");
    expect_silent("R11");
  endtask

  task automatic t_cmd_reset();
    stream_mode = 2;
    pulse(cmd_reset);
    wait_cyc(2);
    chk("R8", {31'h0, muted}, 32'h1, "muted after reset command");
    chk("R8", {31'h0, locked}, 32'h0, "lock cleared by reset command");
    chk("R8", {29'h0, offset}, 32'h0, "offset cleared by reset command");
    expect_silent("R8");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    rst_ni = 1'b1;
    drv_on = 1'b1;
    wait_cyc(2);
    t_reset();
    t_sync(3, 1'b0, 1, 5);   // expected position (8 - phase) mod 8
    t_data(1'b0);
    t_hold(5);
    t_sync(5, 1'b0, 1, 3);   // host order shifted mid-run
    t_data(1'b0);
    t_ambiguous();
    t_sync(2, 1'b1, 3, 6);   // marker mode
    t_data(1'b1);
    t_cmd_reset();
    finish_run();
  end
endmodule